// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is a single timer channel. It counts down from a programmable reload value. It signals events at two programmable match points and at zero. The stored registers can be read back, and so can the live count.

Each count step comes from one of two sources. By default the channel steps once on every system clock. With clock-select set, it steps only when an externally generated one-microsecond strobe is high for a cycle.

The interrupt output is a level that inverts on every qualifying event rather than pulsing. A receiver therefore detects either edge. The two match registers may hold values in either order. Because the count falls, the larger match is always met before the smaller one, and both are met before zero.

When the count is zero, the next step restores the reload value and counting carries on. Software may overwrite the running count. It may also start a channel whose reload was still zero by writing the reload register.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the count output, the read-back of every register and `irq` are all zero.
- R2: While `extClkSel` is 0 and the channel is running, the count falls by one on every clock edge.
- R3: While `extClkSel` is 1 and the channel is running, the count falls by one only on edges where `usTick` is 1. On other edges it holds.
- R4: A step taken while the count is zero loads the reload value into the count. This step never changes `irq`.
- R5: A step that brings the count to a non-zero value equal to either match register inverts `irq` on that same edge. If both matches hold that value, `irq` inverts only once.
- R6: A step that brings the count to zero inverts `irq` only when `ovfIrqEn` is 1 or either match register is zero.
- R7: While `chEnable` is 0, the count output shows the reload register and does not change. `irq` also holds.
- R8: A count write (`cntWrEn`) made while running replaces the count on that edge and takes priority over a step in that cycle. Counting then continues down from the written value.
- R9: A reload write always updates the reload register. While running, it also loads the written value into the count, but only if the old reload was zero and the written value is non-zero. Otherwise the count is untouched.
- R10: On the first edge where `chEnable` is 1 after it was 0, the count is loaded from the reload register and no step is taken. Stepping starts on the edge after that.
- R11: The value on `rdData` depends on `rdSel`:
  - `rdSel`=0 gives the count output.
  - `rdSel`=1 gives the reload register.
  - `rdSel`=2 gives match 0.
  - `rdSel`=3 gives match 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe from the 1 MHz reference |
| chEnable | input | 1 | Channel run control |
| extClkSel | input | 1 | 1: step on `usTick`; 0: step every clock |
| ovfIrqEn | input | 1 | Allow an event when the count reaches zero |
| cntWrEn | input | 1 | Write strobe for the count |
| reloadWrEn | input | 1 | Write strobe for the reload register |
| matchWrEn | input | NUM_MATCH | Write strobes for the match registers; bit i selects match i |
| wrData | input | CNT_W | Write data shared by all write strobes |
| rdSel | input | 2 | Read-back select (see R11) |
| count | output | CNT_W | Live count while running, reload value while disabled |
| rdData | output | CNT_W | Selected register read-back |
| irq | output | 1 | Interrupt level that inverts on each event |

## Verification
Every control and write input acts on the next rising edge. The count, the stored registers and `irq` all show their new values directly after that edge, with no further latency. `rdData` follows `rdSel` combinationally.

The bench drives inputs on the falling edge and updates its own expected state on the rising edge. It compares `count`, `rdData` and `irq` on the next falling edge, so every result is sampled exactly one edge after the stimulus that caused it.

A fixed-seed random phase mixes write strobes, enable changes, clock-select changes and sparse `usTick` pulses. Directed runs cover the following cases:
- matches in both orders
- equal matches
- a zero match
- the reload-from-zero start

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // Mutually exclusive count-update strobes from control to datapath.
  typedef struct packed {
    logic loadReload;   // enable rising edge
    logic loadWrite;    // software count write
    logic loadNew;      // reload write starting a zero-reload channel
    logic step;         // one count step
  } dmtStrobe_t;

  // Comparison results from datapath to control.
  typedef struct packed {
    logic cntIsZero;
    logic nextIsZero;
    logic nextHitsMatch;
    logic anyMatchZero;
    logic startOnReload;
  } dmtStatus_t;

endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       chEnable,
  input  logic       extClkSel,
  input  logic       ovfIrqEn,
  input  logic       cntWrEn,
  input  logic       reloadWrEn,
  input  dmtStatus_t status,
  output dmtStrobe_t strobe,
  output logic       enQ,
  output logic       irq
);

  logic running;
  logic riseEn;
  logic tickOk;
  logic reloadStart;
  logic eventHit;
  logic irqQ;

  assign running     = chEnable & enQ;
  assign riseEn      = chEnable & ~enQ;
  assign tickOk      = extClkSel ? usTick : 1'b1;
  assign reloadStart = reloadWrEn & status.startOnReload;

  always_comb begin
    strobe.loadReload = riseEn;
    strobe.loadWrite  = running & cntWrEn;
    strobe.loadNew    = running & ~cntWrEn & reloadStart;
    strobe.step       = running & ~cntWrEn & ~reloadStart & tickOk;
  end

  // A wrap step from zero never qualifies; a step into zero is gated.
  always_comb begin
    eventHit = 1'b0;
    if (strobe.step && !status.cntIsZero) begin
      if (status.nextIsZero)
        eventHit = ovfIrqEn | status.anyMatchZero;
      else
        eventHit = status.nextHitsMatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      enQ  <= chEnable;
      irqQ <= irqQ ^ eventHit;
    end
  end

  assign irq = irqQ;

  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadReload, strobe.loadWrite, strobe.loadNew, strobe.step}));

  // R5
  irq_needs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqQ) |-> $past(strobe.step));

  // R7
  irq_hold_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chEnable |=> $stable(irqQ));

  // R4
  wrap_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && status.cntIsZero) |=> $stable(irqQ));

endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chEnable,
  input  logic                 enQ,
  input  dmtStrobe_t           strobe,
  input  logic                 reloadWrEn,
  input  logic [NUM_MATCH-1:0] matchWrEn,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [SEL_W-1:0]     rdSel,
  output dmtStatus_t           status,
  output logic [CNT_W-1:0]     countOut,
  output logic [CNT_W-1:0]     rdData
);

  logic [CNT_W-1:0]     cntQ;
  logic [CNT_W-1:0]     reloadQ;
  logic [CNT_W-1:0]     nextVal;
  logic [CNT_W-1:0]     matchQ [NUM_MATCH];
  logic [NUM_MATCH-1:0] hitVec;
  logic [NUM_MATCH-1:0] zeroVec;

  assign nextVal = cntQ - CNT_W'(1);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    always_ff @(posedge clk) begin
      if (!rstN)
        matchQ[i] <= '0;
      else if (matchWrEn[i])
        matchQ[i] <= wrData;
    end
    assign hitVec[i]  = (nextVal == matchQ[i]);
    assign zeroVec[i] = (matchQ[i] == '0);
  end

  always_comb begin
    status.cntIsZero     = (cntQ == '0);
    status.nextIsZero    = (cntQ == CNT_W'(1));
    status.nextHitsMatch = |hitVec;
    status.anyMatchZero  = |zeroVec;
    status.startOnReload = (reloadQ == '0) && (wrData != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      reloadQ <= '0;
    end else begin
      if (reloadWrEn)
        reloadQ <= wrData;
      if (strobe.loadReload)
        cntQ <= reloadQ;
      else if (strobe.loadWrite || strobe.loadNew)
        cntQ <= wrData;
      else if (strobe.step)
        cntQ <= status.cntIsZero ? reloadQ : nextVal;
    end
  end

  assign countOut = enQ ? cntQ : reloadQ;

  always_comb begin
    rdData = '0;
    if (rdSel == SEL_W'(0))
      rdData = countOut;
    else if (rdSel == SEL_W'(1))
      rdData = reloadQ;
    else begin
      for (int k = 0; k < NUM_MATCH; k++)
        if (rdSel == SEL_W'(k + 2))
          rdData = matchQ[k];
    end
  end

  // R7
  count_hold_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chEnable |=> $stable(cntQ));

  // R2
  step_decrement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cntQ != '0) |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R4
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && cntQ == '0 && !reloadWrEn) |=> (cntQ == $past(reloadQ)));

  // R10
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chEnable && !enQ && !reloadWrEn) |=> (countOut == $past(reloadQ)));

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 2,
  localparam int SEL_W    = $clog2(NUM_MATCH + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usTick,
  input  logic                 chEnable,
  input  logic                 extClkSel,
  input  logic                 ovfIrqEn,
  input  logic                 cntWrEn,
  input  logic                 reloadWrEn,
  input  logic [NUM_MATCH-1:0] matchWrEn,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [SEL_W-1:0]     rdSel,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     rdData,
  output logic                 irq
);

  dmtStrobe_t strobe;
  dmtStatus_t status;
  logic       enQ;

  dmt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .usTick     (usTick),
    .chEnable   (chEnable),
    .extClkSel  (extClkSel),
    .ovfIrqEn   (ovfIrqEn),
    .cntWrEn    (cntWrEn),
    .reloadWrEn (reloadWrEn),
    .status     (status),
    .strobe     (strobe),
    .enQ        (enQ),
    .irq        (irq)
  );

  dmt_datapath #(
    .CNT_W     (CNT_W),
    .NUM_MATCH (NUM_MATCH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .chEnable   (chEnable),
    .enQ        (enQ),
    .strobe     (strobe),
    .reloadWrEn (reloadWrEn),
    .matchWrEn  (matchWrEn),
    .wrData     (wrData),
    .rdSel      (rdSel),
    .status     (status),
    .countOut   (count),
    .rdData     (rdData)
  );

endmodule

// File: tb/dual_match_timer_tb.sv
`timescale 1ns/1ps
module dual_match_timer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        usTick, chEnable, extClkSel, ovfIrqEn, cntWrEn, reloadWrEn;
  logic [1:0]  matchWrEn;
  logic [31:0] wrData;
  logic [1:0]  rdSel;
  logic [31:0] count, rdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [31:0] mCnt, mRel, mM0, mM1;
  logic        mIrq, mEn;
  string       lastTag;

  always #10 clk = ~clk;

  dual_match_timer u_dut (
    .clk(clk), .rstN(rstN), .usTick(usTick), .chEnable(chEnable),
    .extClkSel(extClkSel), .ovfIrqEn(ovfIrqEn), .cntWrEn(cntWrEn),
    .reloadWrEn(reloadWrEn), .matchWrEn(matchWrEn), .wrData(wrData),
    .rdSel(rdSel), .count(count), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [1:0] sel);
    case (sel)
      2'd0:    return mEn ? mCnt : mRel;
      2'd1:    return mRel;
      2'd2:    return mM0;
      default: return mM1;
    endcase
  endfunction

  // Expected-state update for one rising edge, from the requirements.
  task automatic modelEdge();
    logic        rise, tickOk;
    logic [31:0] v;
    rise    = chEnable && !mEn;
    tickOk  = extClkSel ? usTick : 1'b1;
    lastTag = "R7";
    if (chEnable) begin
      if (rise) begin
        mCnt = mRel; lastTag = "R10";
      end else if (cntWrEn) begin
        mCnt = wrData; lastTag = "R8";
      end else if (reloadWrEn && mRel == 0 && wrData != 0) begin
        mCnt = wrData; lastTag = "R9";
      end else if (tickOk) begin
        if (mCnt == 0) begin
          mCnt = mRel; lastTag = "R4";
        end else begin
          v = mCnt - 1;
          if (v == 0) begin
            lastTag = "R6";
            if (ovfIrqEn || mM0 == 0 || mM1 == 0) mIrq = ~mIrq;
          end else if (v == mM0 || v == mM1) begin
            lastTag = "R5"; mIrq = ~mIrq;
          end else begin
            lastTag = extClkSel ? "R3" : "R2";
          end
          mCnt = v;
        end
      end else if (extClkSel) begin
        lastTag = "R3";
      end
    end
    if (reloadWrEn)   mRel = wrData;
    if (matchWrEn[0]) mM0 = wrData;
    if (matchWrEn[1]) mM1 = wrData;
    mEn = chEnable;
  endtask

  // Inputs set before this call (on a falling edge); results checked on the next falling edge.
  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(lastTag, count, mEn ? mCnt : mRel);
    check(lastTag, {31'b0, irq}, {31'b0, mIrq});
    check("R11", rdData, expRead(rdSel));
  endtask

  task automatic idleIn();
    usTick = 0; cntWrEn = 0; reloadWrEn = 0; matchWrEn = 0; wrData = 0;
  endtask

  task automatic wr(input int which, input logic [31:0] val);
    idleIn();
    wrData = val;
    case (which)
      0: cntWrEn = 1;
      1: reloadWrEn = 1;
      2: matchWrEn = 2'b01;
      default: matchWrEn = 2'b10;
    endcase
    cycle();
    idleIn();
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    int seedDummy;
    logic irqRef;
    seedDummy = $urandom(32'h5EED_0042);
    rstN = 0; chEnable = 0; extClkSel = 0; ovfIrqEn = 0; rdSel = 0;
    idleIn();
    mCnt = 0; mRel = 0; mM0 = 0; mM1 = 0; mIrq = 0; mEn = 0;
    repeat (3) @(negedge clk);
    // R1: reset values across every read-back selection
    for (int s = 0; s < 4; s++) begin
      rdSel = 2'(s);
      #1;
      check("R1", rdData, 32'd0);
    end
    check("R1", count, 32'd0);
    check("R1", {31'b0, irq}, 32'd0);
    rstN = 1;
    rdSel = 0;

    // Matches written larger-second; bus clock; no overflow event
    wr(1, 32'd6); wr(2, 32'd2); wr(3, 32'd4);
    check("R7", count, 32'd6);
    chEnable = 1;
    cycle();
    check("R10", count, 32'd6);
    cycle();
    check("R2", count, 32'd5);
    irqRef = irq;
    cycle();
    check("R5", count, 32'd4);
    check("R5", {31'b0, irq}, {31'b0, ~irqRef});
    runCycles(4);
    check("R6", count, 32'd0);
    check("R6", {31'b0, irq}, {31'b0, irqRef});
    cycle();
    check("R4", count, 32'd6);
    check("R4", {31'b0, irq}, {31'b0, irqRef});

    // Equal matches toggle once; zero match forces zero event
    wr(2, 32'd3); wr(3, 32'd3);
    runCycles(14);
    wr(2, 32'd0);
    runCycles(14);
    ovfIrqEn = 1; wr(2, 32'd5);
    runCycles(10);

    // Count write continues from written value
    wr(0, 32'd9);
    check("R8", count, 32'd9);
    cycle();
    check("R8", count, 32'd8);

    // External tick mode
    extClkSel = 1;
    runCycles(3);
    check("R3", count, 32'd8);
    usTick = 1; cycle(); usTick = 0;
    check("R3", count, 32'd7);
    runCycles(2);
    check("R3", count, 32'd7);

    // Reload start from zero reload, and no start from non-zero reload
    extClkSel = 0;
    chEnable = 0; cycle();
    wr(1, 32'd0);
    chEnable = 1; cycle();
    check("R10", count, 32'd0);
    wr(1, 32'd12);
    check("R9", count, 32'd12);
    wr(1, 32'd20);
    check("R9", count, 32'd11);
    check("R9", mRel, 32'd20);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      idleIn();
      if ($urandom() % 64 == 0)  chEnable  = ~chEnable;
      if ($urandom() % 100 == 0) extClkSel = ~extClkSel;
      if ($urandom() % 50 == 0)  ovfIrqEn  = ~ovfIrqEn;
      usTick = ($urandom() % 3 == 0);
      wrData = $urandom() % 24;
      if ($urandom() % 40 == 0) cntWrEn = 1;
      if ($urandom() % 40 == 0) reloadWrEn = 1;
      if ($urandom() % 40 == 0) matchWrEn[0] = 1;
      if ($urandom() % 40 == 0) matchWrEn[1] = 1;
      if ($urandom() % 200 == 0) wrData = 0;
      rdSel = 2'($urandom() % 4);
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule